// File: doc/BRIEF.md
# Two-Way Mixed-Page-Size Translation Buffer

This block caches virtual-to-physical translations for a virtual-memory unit. It holds sixteen entries, arranged as eight sets of two ways. Every entry carries its own page size, from 1 KB up to 16 MB, so a handful of entries can map very large regions. A lookup is purely combinational. It takes a virtual address, a process ID, a privilege flag and an access kind, and returns a hit, the translated physical address, a protection fault and a multiple-match flag, all in the same cycle.

Software loads entries through a synchronous write port. The target way is either given explicitly or taken from the set's replacement state. The set is always derived from the written address and its page size. Each set has a two-state replacement machine. Its states are `VICT_W0` (way 0 is next to be refilled) and `VICT_W1` (way 1 is next).

The machine has five named transitions:
- `FILL_W0` moves to `VICT_W1`.
- `FILL_W1` moves to `VICT_W0`.
- `TOUCH_W0` moves from `VICT_W0` to `VICT_W1`.
- `TOUCH_W1` moves from `VICT_W1` to `VICT_W0`.
- `HOLD` leaves the state as it is.

Fills take precedence over touches.

Protection is asymmetric. User accesses are checked against separate read, write and execute permissions. Supervisor reads and fetches are never refused, and only supervisor writes are checked.

Top module: `largepage_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns lk_hit=0, lk_multi=0 and lk_fault=0, and every set's replacement state is VICT_W0.
- R2: An entry matches only when it is valid, its stored process ID equals lk_pid, and lk_vaddr agrees with the stored virtual address on every bit at or above the entry's page offset.
- R3: wr_size encodes the page size: 0 is 1 KB (10 offset bits), 1 is 64 KB (16), 2 is 1 MB (20) and 3 is 16 MB (24). On a hit, lk_paddr takes the stored physical address above the offset and lk_vaddr below it.
- R4: A write goes to the set given by the three wr_vaddr bits just above the offset for wr_size. Entries of different sizes can share a set, and each is compared under its own size.
- R5: A write takes effect at the rising edge where wr_en is sampled high. A lookup in the same cycle sees the old contents.
- R6: With wr_use_lru=0 the write goes to way wr_way. With wr_use_lru=1 it goes to the way named by the set's replacement state.
- R7: A write to a set moves its state to name the other way from the one written (FILL_W0, FILL_W1). Otherwise, a lookup with lk_touch=1 that hits exactly one entry moves that set's state to name the other way (TOUCH_W0, TOUCH_W1). A fill overrides a touch in the same cycle.
- R8: A lookup with lk_touch=0 never changes any replacement state.
- R9: wr_perm bit 0 grants user read, bit 1 user write, bit 2 user execute and bit 3 supervisor write. With lk_super=0, lk_access 0 (load) needs bit 0, 1 (store) needs bit 1, and 2 or 3 (fetch) needs bit 2. Otherwise lk_fault=1.
- R10: With lk_super=1, loads and fetches never fault, and a store faults unless bit 3 is set.
- R11: lk_fault is 0 whenever lk_hit is 0.
- R12: When more than one entry matches, lk_multi=1 and lk_hit=1. lk_paddr and lk_fault then come from the matching entry with the lowest index (set*2+way).
- R13: A write with wr_valid=0 invalidates the chosen entry, and its address no longer hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_touch | input | 1 | Lookup counts for replacement |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_pid | input | PID_W | Lookup process ID |
| lk_super | input | 1 | Supervisor privilege |
| lk_access | input | 2 | 0 load, 1 store, 2/3 fetch |
| lk_hit | output | 1 | Some entry matches |
| lk_multi | output | 1 | More than one entry matches |
| lk_fault | output | 1 | Protection violation on the hit |
| lk_paddr | output | PA_W | Translated physical address |
| wr_en | input | 1 | Write an entry |
| wr_valid | input | 1 | Valid bit written |
| wr_use_lru | input | 1 | Take way from replacement state |
| wr_way | input | 1 | Explicit way |
| wr_size | input | 2 | Page size code |
| wr_vaddr | input | VA_W | Virtual page address |
| wr_pid | input | PID_W | Process ID |
| wr_paddr | input | PA_W | Physical page address |
| wr_perm | input | 4 | Permission bits |

## Verification
Translation is tried with pages of all four sizes. Each size is probed inside the page, just past its end, and with a wrong process ID, which separates the offset mask from the tag compare. Two sizes are placed in one set, first in the same way and then in different ways. This shows whether the set index follows the page size. Fill and lookup sequences with touch on and off, including a touch and a fill in the same cycle, show which way each refill evicts. Permission checks cover every access kind in both privileges. Overlaps within a set and across sets show the multiple-match flag and the lowest-index priority.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    // smallest page: 1 KB
    localparam int unsigned MIN_OFF = 10;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_t;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;

    typedef struct packed {
        logic sup_wr;
        logic usr_ex;
        logic usr_wr;
        logic usr_rd;
    } perm_t;

    function automatic int unsigned off_bits(input logic [1:0] sz);
        int unsigned r;
        unique case (pg_size_t'(sz))
            PG_1K:  r = MIN_OFF;
            PG_64K: r = MIN_OFF + 6;
            PG_1M:  r = MIN_OFF + 10;
            PG_16M: r = MIN_OFF + 14;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lpt_entry.sv
module lpt_entry
    import lpt_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             wr_valid,
    input  logic [VA_W-1:0]  wr_vaddr,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [1:0]       wr_size,
    input  logic [PA_W-1:0]  wr_paddr,
    input  perm_t            wr_perm,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    output logic             match,
    output logic [PA_W-1:0]  xlat_pa,
    output perm_t            perm_o
);

    localparam int LOW_W = (VA_W < PA_W) ? VA_W : PA_W;

    logic             e_valid;
    logic [VA_W-1:0]  e_va;
    logic [PID_W-1:0] e_pid;
    logic [1:0]       e_size;
    logic [PA_W-1:0]  e_pa;
    perm_t            e_perm;

    logic [VA_W-1:0]  va_mask;
    logic [PA_W-1:0]  pa_keep;
    logic [PA_W-1:0]  va_low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
            e_va    <= '0;
            e_pid   <= '0;
            e_size  <= '0;
            e_pa    <= '0;
            e_perm  <= '0;
        end else if (wr_sel) begin
            e_valid <= wr_valid;
            e_va    <= wr_vaddr;
            e_pid   <= wr_pid;
            e_size  <= wr_size;
            e_pa    <= wr_paddr;
            e_perm  <= wr_perm;
        end
    end

    always_comb begin
        va_mask = {VA_W{1'b1}} << off_bits(e_size);
        pa_keep = {PA_W{1'b1}} << off_bits(e_size);
        va_low  = '0;
        for (int i = 0; i < LOW_W; i++) begin
            va_low[i] = lk_vaddr[i];
        end
    end

    always_comb begin
        match   = e_valid && (e_pid == lk_pid) &&
                  (((lk_vaddr ^ e_va) & va_mask) == '0);
        xlat_pa = (e_pa & pa_keep) | (va_low & ~pa_keep);
        perm_o  = e_perm;
    end

endmodule

// File: rtl/lpt_lru.sv
module lpt_lru (
    input  logic clk,
    input  logic rst_n,
    input  logic touch_w0,
    input  logic touch_w1,
    input  logic fill_en,
    input  logic fill_way,
    output logic victim
);

    typedef enum logic {
        VICT_W0 = 1'b0,
        VICT_W1 = 1'b1
    } lru_state_t;

    lru_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= VICT_W0;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            VICT_W0: begin
                if (fill_en) begin
                    nxt = fill_way ? VICT_W0 : VICT_W1;
                end else if (touch_w0) begin
                    nxt = VICT_W1;
                end
            end
            VICT_W1: begin
                if (fill_en) begin
                    nxt = fill_way ? VICT_W0 : VICT_W1;
                end else if (touch_w1) begin
                    nxt = VICT_W0;
                end
            end
        endcase
    end

    always_comb begin
        victim = (state == VICT_W1);
    end

endmodule

// File: rtl/lpt_select.sv
module lpt_select
    import lpt_pkg::*;
#(
    parameter int N    = 16,
    parameter int PA_W = 32
) (
    input  logic [N-1:0]    hit_vec,
    input  logic [PA_W-1:0] pa_arr [N],
    input  perm_t           perm_arr [N],
    input  logic            lk_super,
    input  logic [1:0]      lk_access,
    output logic            hit,
    output logic            multi,
    output logic            fault,
    output logic [PA_W-1:0] paddr
);

    perm_t pm;
    logic  deny;

    always_comb begin
        paddr = '0;
        pm    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                paddr = pa_arr[i];
                pm    = perm_arr[i];
            end
        end
    end

    always_comb begin
        if (lk_access == ACC_LOAD) begin
            deny = lk_super ? 1'b0 : !pm.usr_rd;
        end else if (lk_access == ACC_STORE) begin
            deny = lk_super ? !pm.sup_wr : !pm.usr_wr;
        end else begin
            deny = lk_super ? 1'b0 : !pm.usr_ex;
        end
    end

    always_comb begin
        hit   = |hit_vec;
        multi = |(hit_vec & (hit_vec - {{(N-1){1'b0}}, 1'b1}));
        fault = hit && deny;
    end

endmodule

// File: rtl/largepage_tlb.sv
module largepage_tlb
    import lpt_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PID_W = 8,
    parameter int SETS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_touch,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_super,
    input  logic [1:0]       lk_access,
    output logic             lk_hit,
    output logic             lk_multi,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             wr_en,
    input  logic             wr_valid,
    input  logic             wr_use_lru,
    input  logic             wr_way,
    input  logic [1:0]       wr_size,
    input  logic [VA_W-1:0]  wr_vaddr,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [PA_W-1:0]  wr_paddr,
    input  logic [3:0]       wr_perm
);

    localparam int WAYS  = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int N     = SETS * WAYS;

    logic [SET_W-1:0] wr_set;
    logic             fill_way;
    logic [SETS-1:0]  victim;
    logic [N-1:0]     hit_vec;
    logic [PA_W-1:0]  pa_arr   [N];
    perm_t            perm_arr [N];

    always_comb begin
        wr_set   = wr_vaddr[off_bits(wr_size) +: SET_W];
        fill_way = wr_use_lru ? victim[wr_set] : wr_way;
    end

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic fill_here;
        assign fill_here = wr_en && (wr_set == SET_W'(s));

        for (genvar w = 0; w < WAYS; w++) begin : g_way
            lpt_entry #(
                .VA_W (VA_W),
                .PA_W (PA_W),
                .PID_W(PID_W)
            ) u_entry (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (fill_here && (fill_way == 1'(w))),
                .wr_valid(wr_valid),
                .wr_vaddr(wr_vaddr),
                .wr_pid  (wr_pid),
                .wr_size (wr_size),
                .wr_paddr(wr_paddr),
                .wr_perm (perm_t'(wr_perm)),
                .lk_vaddr(lk_vaddr),
                .lk_pid  (lk_pid),
                .match   (hit_vec[s*WAYS+w]),
                .xlat_pa (pa_arr[s*WAYS+w]),
                .perm_o  (perm_arr[s*WAYS+w])
            );
        end

        lpt_lru u_lru (
            .clk     (clk),
            .rst_n   (rst_n),
            .touch_w0(lk_touch && !lk_multi && hit_vec[s*WAYS]),
            .touch_w1(lk_touch && !lk_multi && hit_vec[s*WAYS+1]),
            .fill_en (fill_here),
            .fill_way(fill_way),
            .victim  (victim[s])
        );
    end

    lpt_select #(
        .N   (N),
        .PA_W(PA_W)
    ) u_select (
        .hit_vec  (hit_vec),
        .pa_arr   (pa_arr),
        .perm_arr (perm_arr),
        .lk_super (lk_super),
        .lk_access(lk_access),
        .hit      (lk_hit),
        .multi    (lk_multi),
        .fault    (lk_fault),
        .paddr    (lk_paddr)
    );

endmodule

// File: rtl/largepage_tlb_chk.sv
module largepage_tlb_chk
    import lpt_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int SET_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_touch,
    input logic               lk_super,
    input logic [1:0]         lk_access,
    input logic [MIN_OFF-1:0] lk_vaddr_lo,
    input logic [MIN_OFF-1:0] lk_paddr_lo,
    input logic               lk_hit,
    input logic               lk_multi,
    input logic               lk_fault,
    input logic               wr_en,
    input logic [SET_W-1:0]   wr_set,
    input logic               fill_way,
    input logic [2*SETS-1:0]  hit_vec,
    input logic [SETS-1:0]    victim
);

    // R11
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R12
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr_lo == lk_vaddr_lo));

    // R10
    sup_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_super && lk_access != ACC_STORE) |-> !lk_fault);

    // R8
    no_touch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_touch && !wr_en) |=> $stable(victim));

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        // R7
        lru_touch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_touch && !lk_multi && hit_vec[2*s] &&
             !(wr_en && wr_set == SET_W'(s))) |=> victim[s]);

        // R7
        lru_touch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_touch && !lk_multi && hit_vec[2*s+1] &&
             !(wr_en && wr_set == SET_W'(s))) |=> !victim[s]);

        // R7
        lru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_set == SET_W'(s)) |=> (victim[s] == !$past(fill_way)));
    end

endmodule

bind largepage_tlb largepage_tlb_chk #(
    .SETS (SETS),
    .SET_W(SET_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_touch   (lk_touch),
    .lk_super   (lk_super),
    .lk_access  (lk_access),
    .lk_vaddr_lo(lk_vaddr[lpt_pkg::MIN_OFF-1:0]),
    .lk_paddr_lo(lk_paddr[lpt_pkg::MIN_OFF-1:0]),
    .lk_hit     (lk_hit),
    .lk_multi   (lk_multi),
    .lk_fault   (lk_fault),
    .wr_en      (wr_en),
    .wr_set     (wr_set),
    .fill_way   (fill_way),
    .hit_vec    (hit_vec),
    .victim     (victim)
);

// File: tb/largepage_tlb_test.sv
module largepage_tlb_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_touch = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_super = 1'b0;
    logic [1:0]  lk_access = '0;
    logic        lk_hit, lk_multi, lk_fault;
    logic [31:0] lk_paddr;
    logic        wr_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_use_lru = 1'b0;
    logic        wr_way = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_vaddr = '0;
    logic [7:0]  wr_pid = '0;
    logic [31:0] wr_paddr = '0;
    logic [3:0]  wr_perm = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    largepage_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_touch(lk_touch), .lk_vaddr(lk_vaddr),
        .lk_pid(lk_pid), .lk_super(lk_super), .lk_access(lk_access),
        .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_fault(lk_fault),
        .lk_paddr(lk_paddr), .wr_en(wr_en), .wr_valid(wr_valid),
        .wr_use_lru(wr_use_lru), .wr_way(wr_way), .wr_size(wr_size),
        .wr_vaddr(wr_vaddr), .wr_pid(wr_pid), .wr_paddr(wr_paddr),
        .wr_perm(wr_perm)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lk_touch = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] va, input logic [7:0] pid,
                            input logic [1:0] sz, input logic [31:0] pa,
                            input logic [3:0] perm, input logic vld,
                            input logic use_lru, input logic way);
        @(negedge clk);
        lk_touch = 1'b0;
        wr_en = 1'b1; wr_vaddr = va; wr_pid = pid; wr_size = sz;
        wr_paddr = pa; wr_perm = perm; wr_valid = vld;
        wr_use_lru = use_lru; wr_way = way;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] pid,
                        input logic sup, input logic [1:0] acc, input logic touch);
        @(negedge clk);
        wr_en = 1'b0;
        lk_vaddr = va; lk_pid = pid; lk_super = sup;
        lk_access = acc; lk_touch = touch;
        #1;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] pa);
        check(req, "hit", 32'(lk_hit), 32'd1);
        check(req, "paddr", lk_paddr, pa);
    endtask

    task automatic expect_miss(input string req);
        check(req, "hit", 32'(lk_hit), 32'd0);
    endtask

    // R1: reset state and initial replacement choice
    task automatic t_reset();
        do_reset();
        look(32'h0000_1234, 8'd0, 1'b0, 2'd1, 1'b0);
        check("R1", "hit after reset", 32'(lk_hit), 32'd0);
        check("R1", "multi after reset", 32'(lk_multi), 32'd0);
        check("R1", "fault after reset", 32'(lk_fault), 32'd0);
        do_write(32'h0000_0C00, 8'd1, 2'd0, 32'h1000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        do_write(32'h0000_0C00, 8'd1, 2'd0, 32'h2000_0000, 4'hF, 1'b1, 1'b0, 1'b1);
        look(32'h0000_0C00, 8'd1, 1'b0, 2'd0, 1'b0);
        check("R1", "first lru fill went to way0", 32'(lk_multi), 32'd1);
    endtask

    // R2 R5: basic match and write timing
    task automatic t_basic();
        do_reset();
        do_write(32'h0000_1C00, 8'd5, 2'd0, 32'h8000_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        look(32'h0000_1C34, 8'd5, 1'b0, 2'd0, 1'b0);
        expect_hit("R2", 32'h8000_0034);
        look(32'h0000_2034, 8'd5, 1'b0, 2'd0, 1'b0);
        expect_miss("R2");
        look(32'h0100_1C34, 8'd5, 1'b0, 2'd0, 1'b0);
        expect_miss("R2");
        look(32'h0000_1C34, 8'd6, 1'b0, 2'd0, 1'b0);
        expect_miss("R2");
        // R5: lookup concurrent with the write sees the old contents
        @(negedge clk);
        wr_en = 1'b1; wr_vaddr = 32'h0000_0800; wr_pid = 8'd5; wr_size = 2'd0;
        wr_paddr = 32'hA000_0000; wr_perm = 4'hF; wr_valid = 1'b1;
        wr_use_lru = 1'b0; wr_way = 1'b0;
        lk_vaddr = 32'h0000_0805; lk_pid = 8'd5; lk_touch = 1'b0;
        #1;
        check("R5", "hit during write cycle", 32'(lk_hit), 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        expect_hit("R5", 32'hA000_0005);
    endtask

    // R3 R4: sizes and set placement
    task automatic t_sizes();
        do_reset();
        do_write(32'h0000_1400, 8'd2, 2'd0, 32'h0C00_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        do_write(32'h0005_0000, 8'd2, 2'd1, 32'h1234_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        look(32'h0000_1456, 8'd2, 1'b0, 2'd0, 1'b0);
        check("R4", "64K write replaced 1K in shared set", 32'(lk_hit), 32'd0);
        do_write(32'h0000_1400, 8'd2, 2'd0, 32'h0C00_0000, 4'hF, 1'b1, 1'b0, 1'b1);
        look(32'h0000_1456, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_hit("R4", 32'h0C00_0056);
        look(32'h0005_ABCD, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_hit("R3", 32'h1234_ABCD);
        look(32'h0006_0000, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_miss("R3");
        do_write(32'h0060_0000, 8'd2, 2'd2, 32'h0AB0_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        look(32'h006F_1234, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_hit("R3", 32'h0ABF_1234);
        do_write(32'h0200_0000, 8'd2, 2'd3, 32'h4500_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        look(32'h02AB_CDEF, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_hit("R3", 32'h45AB_CDEF);
        look(32'h0300_0000, 8'd2, 1'b0, 2'd0, 1'b0);
        expect_miss("R3");
    endtask

    // R9 R10 R11: protection
    task automatic t_perm();
        do_reset();
        do_write(32'h0000_0400, 8'd1, 2'd0, 32'h5000_0000, 4'b0001, 1'b1, 1'b0, 1'b0);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd0, 1'b0);
        check("R9", "user load allowed", 32'(lk_fault), 32'd0);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd1, 1'b0);
        check("R9", "user store denied", 32'(lk_fault), 32'd1);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd2, 1'b0);
        check("R9", "user fetch denied", 32'(lk_fault), 32'd1);
        look(32'h0000_0404, 8'd1, 1'b1, 2'd0, 1'b0);
        check("R10", "sup load never faults", 32'(lk_fault), 32'd0);
        look(32'h0000_0404, 8'd1, 1'b1, 2'd3, 1'b0);
        check("R10", "sup fetch never faults", 32'(lk_fault), 32'd0);
        look(32'h0000_0404, 8'd1, 1'b1, 2'd1, 1'b0);
        check("R10", "sup store without bit3", 32'(lk_fault), 32'd1);
        do_write(32'h0000_0400, 8'd1, 2'd0, 32'h5000_0000, 4'b1000, 1'b1, 1'b0, 1'b0);
        look(32'h0000_0404, 8'd1, 1'b1, 2'd1, 1'b0);
        check("R10", "sup store with bit3", 32'(lk_fault), 32'd0);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd0, 1'b0);
        check("R9", "user load without bit0", 32'(lk_fault), 32'd1);
        do_write(32'h0000_0400, 8'd1, 2'd0, 32'h5000_0000, 4'b0110, 1'b1, 1'b0, 1'b0);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd1, 1'b0);
        check("R9", "user store with bit1", 32'(lk_fault), 32'd0);
        look(32'h0000_0404, 8'd1, 1'b0, 2'd2, 1'b0);
        check("R9", "user fetch with bit2", 32'(lk_fault), 32'd0);
        look(32'h0000_8404, 8'd1, 1'b0, 2'd1, 1'b0);
        check("R11", "miss never faults", 32'(lk_fault), 32'd0);
    endtask

    // R6 R7 R8: replacement
    task automatic t_lru();
        do_reset();
        do_write(32'h0003_0000, 8'd3, 2'd1, 32'h1000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        do_write(32'h0013_0000, 8'd3, 2'd1, 32'h2000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        look(32'h0003_0010, 8'd3, 1'b0, 2'd0, 1'b1);
        do_write(32'h0023_0000, 8'd3, 2'd1, 32'h3000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        look(32'h0013_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        check("R7", "touch way0 made way1 victim", 32'(lk_hit), 32'd0);
        look(32'h0003_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        expect_hit("R7", 32'h1000_0010);
        look(32'h0023_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        expect_hit("R6", 32'h3000_0010);
        do_write(32'h0033_0000, 8'd3, 2'd1, 32'h4000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        look(32'h0003_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        check("R8", "untouched probe left way0 victim", 32'(lk_hit), 32'd0);
        look(32'h0023_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        expect_hit("R8", 32'h3000_0010);
        look(32'h0023_0020, 8'd3, 1'b0, 2'd0, 1'b1);
        do_write(32'h0043_0000, 8'd3, 2'd1, 32'h5000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        look(32'h0033_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        check("R7", "touch way1 made way0 victim", 32'(lk_hit), 32'd0);
        look(32'h0023_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        expect_hit("R7", 32'h3000_0010);
    endtask

    // R7: fill and touch in the same cycle, fill wins
    task automatic t_collide();
        do_reset();
        do_write(32'h0003_0000, 8'd3, 2'd1, 32'h1000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        lk_vaddr = 32'h0003_0010; lk_pid = 8'd3; lk_touch = 1'b1;
        wr_en = 1'b1; wr_vaddr = 32'h0013_0000; wr_pid = 8'd3; wr_size = 2'd1;
        wr_paddr = 32'h2000_0000; wr_perm = 4'hF; wr_valid = 1'b1;
        wr_use_lru = 1'b1; wr_way = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_touch = 1'b0;
        do_write(32'h0023_0000, 8'd3, 2'd1, 32'h3000_0000, 4'hF, 1'b1, 1'b1, 1'b0);
        look(32'h0003_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        check("R7", "fill beat touch, way0 refilled", 32'(lk_hit), 32'd0);
        look(32'h0013_0010, 8'd3, 1'b0, 2'd0, 1'b0);
        expect_hit("R7", 32'h2000_0010);
    endtask

    // R12 R13 R6: multiple matches and invalidation
    task automatic t_multi();
        do_reset();
        do_write(32'h0000_0C00, 8'd4, 2'd0, 32'h5000_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        do_write(32'h0000_0C00, 8'd4, 2'd0, 32'h6000_0000, 4'b0000, 1'b1, 1'b0, 1'b1);
        look(32'h0000_0C12, 8'd4, 1'b0, 2'd1, 1'b0);
        check("R12", "multi same set", 32'(lk_multi), 32'd1);
        expect_hit("R12", 32'h5000_0012);
        check("R12", "fault from way0 entry", 32'(lk_fault), 32'd0);
        do_write(32'h0000_0C00, 8'd4, 2'd0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0);
        look(32'h0000_0C12, 8'd4, 1'b0, 2'd0, 1'b0);
        check("R13", "multi cleared", 32'(lk_multi), 32'd0);
        expect_hit("R13", 32'h6000_0012);
        do_write(32'h0000_0C00, 8'd4, 2'd0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b1);
        look(32'h0000_0C12, 8'd4, 1'b0, 2'd0, 1'b0);
        expect_miss("R13");
        do_reset();
        do_write(32'h0100_0000, 8'd4, 2'd3, 32'h7000_0000, 4'hF, 1'b1, 1'b0, 1'b1);
        do_write(32'h0100_0800, 8'd4, 2'd0, 32'h9000_0000, 4'hF, 1'b1, 1'b0, 1'b0);
        look(32'h0100_0834, 8'd4, 1'b0, 2'd0, 1'b0);
        check("R12", "multi across sets", 32'(lk_multi), 32'd1);
        expect_hit("R12", 32'h7000_0834);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sizes();
        t_perm();
        t_lru();
        t_collide();
        t_multi();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule